// File: doc/BRIEF.md
# Mode-Steered Data Memory Router

This block sits between an 8-bit microcontroller core and its data memories. On each accepted request it picks one of four targets: a 256-byte internal RAM, a port to the special-function registers (SFRs), a 256-byte on-chip expanded RAM, or an external data bus. The address alone does not decide the target. The addressing mode the core reports decides it together with the address. A single byte address such as A0h can therefore land in upper internal RAM, in an SFR, in expanded RAM or off chip.

Both RAM arrays are held inside the block and answer one clock after the request, with no stall. The SFR port and the external bus are request/acknowledge interfaces. While one of them is pending, the block raises `busy`, holds the latched address and data, and ignores any new request until the acknowledge returns. The external side gives the high address byte, the low address byte, write data and separate active-low read and write strobes. Multiplexing these onto pins is left to a pin-level wrapper.

Top module: `dmem_router`

## Requirements
- R1: With mode code 0 (direct), byte addresses 00h–7Fh (low 8 address bits) select internal RAM. A value written this way can be read back with mode 1 at the same address.
- R2: With mode 0, byte addresses 80h–FFh select the SFR port. `sfrAddr` carries the byte address, and `sfrWrite`/`sfrWdata` carry the write.
- R3: With mode code 1 (indirect, also used for stack pushes and pops), every byte address 00h–FFh selects internal RAM and never the SFR port. Upper RAM at 80h–FFh is separate from the SFRs: an SFR write at an address leaves internal RAM at that address unchanged.
- R4: With mode code 2 (move-external through an 8-bit pointer), the request always selects expanded RAM at the low address byte, whatever the high byte holds. It never starts an external access.
- R5: With mode code 3 (move-external through the 16-bit pointer), addresses 0000h–00FFh select expanded RAM and 0100h–FFFFh select the external bus.
- R6: During an external access, `extAddrHi`/`extAddrLo` carry the high and low address bytes. `extRdN` is low for a read and `extWrN` is low for a write, never both at once. During an expanded-RAM access both strobes stay high and `extAddrLo`/`extWdata` stay 0.
- R7: Internal RAM and expanded RAM are separate arrays. A write to one at byte address A leaves the other at A unchanged.
- R8: `regionHot` is one-hot with bit 0 = internal RAM, bit 1 = SFR, bit 2 = expanded RAM, bit 3 = external. It shows the decoded target combinationally in the request cycle and the held target while busy. It is 0 when there is no request.
- R9: A read of internal or expanded RAM raises `rdValid` with the data on `rdData` in the cycle after acceptance, and `busy` stays low.
- R10: An SFR or external access raises `busy` and its request line from the cycle after acceptance until the cycle after the matching acknowledge. For a read, `rdValid` and the returned byte appear in that same later cycle.
- R11: A cycle with `reqValid` low changes no memory, even with `reqWrite` high. A request presented while `busy` is high is ignored.
- R12: After reset, `busy`, `rdValid`, `sfrReq`, `extReq` and `regionHot` are 0, and both external strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core presents a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 2 | 0 direct, 1 indirect/stack, 2 pointer8 move-external, 3 pointer16 move-external |
| reqAddr | input | 16 | Request address (byte modes use bits 7:0) |
| reqWdata | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdValid |
| rdValid | output | 1 | Read data valid pulse |
| busy | output | 1 | Slow access in progress; core must stall |
| regionHot | output | 4 | One-hot target indicator |
| sfrReq | output | 1 | SFR port request |
| sfrWrite | output | 1 | SFR port write |
| sfrAddr | output | 8 | SFR address |
| sfrWdata | output | 8 | SFR write data |
| sfrAck | input | 1 | SFR acknowledge |
| sfrRdata | input | 8 | SFR read data, taken with sfrAck |
| extReq | output | 1 | External bus request |
| extWrite | output | 1 | External bus write |
| extAddrHi | output | 8 | External high address byte |
| extAddrLo | output | 8 | External low address byte |
| extWdata | output | 8 | External write data |
| extRdN | output | 1 | External read strobe, active low |
| extWrN | output | 1 | External write strobe, active low |
| extAck | input | 1 | External acknowledge |
| extRdata | input | 8 | External read data, taken with extAck |

## Verification
The hardest case to reach from the ports is one byte address sent to all four targets in turn with values that prove separate storage. A0h is written through indirect mode, then through direct mode, which goes to the SFR. A0h is then written through the 8-bit pointer with a nonzero high byte, and finally read back through every path. Directed sequences also drive the pointer16 boundary at 00FFh and 0100h. They issue requests while busy, with a write to the same internal address, to show these are ignored. A seeded random stream of mixed modes, addresses and acknowledge delays is checked against a bench memory model.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_PTR8     = 2'd2,
    MODE_PTR16    = 2'd3
  } accMode_t;

  localparam int REG_IRAM    = 0;
  localparam int REG_SFR     = 1;
  localparam int REG_ERAM    = 2;
  localparam int REG_EXT     = 3;
  localparam int NUM_REGIONS = 4;

  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic iramWe;
    logic eramWe;
    logic iramRd;
    logic eramRd;
    logic takeSfr;
    logic takeExt;
  } dpCtl_t;
endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 8
) (
  input  logic [1:0]             mode,
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_REGIONS-1:0] hot
);
  logic upperZero;
  assign upperZero = (addr[ADDR_W-1:LOCAL_W] == '0);

  always_comb begin
    hot = '0;
    unique case (mode)
      MODE_DIRECT:   hot[addr[LOCAL_W-1] ? REG_SFR : REG_IRAM] = 1'b1;
      MODE_INDIRECT: hot[REG_IRAM] = 1'b1;
      MODE_PTR8:     hot[REG_ERAM] = 1'b1;
      MODE_PTR16:    hot[upperZero ? REG_ERAM : REG_EXT] = 1'b1;
      default:       hot = '0;
    endcase
  end
endmodule

// File: rtl/dmr_ctrl.sv
module dmr_ctrl
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqMode,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   sfrAck,
  input  logic                   extAck,
  output dpCtl_t                 ctl,
  output logic                   busy,
  output logic                   rdValid,
  output logic                   heldWrite,
  output logic                   sfrReq,
  output logic                   extReq,
  output logic [NUM_REGIONS-1:0] regionHot
);
  ctlState_t state;
  logic [NUM_REGIONS-1:0] decHot, heldHot;
  logic accept, slow, ack;

  dmr_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) uDecode (
    .mode(reqMode), .addr(reqAddr), .hot(decHot)
  );

  assign accept = reqValid && (state == ST_IDLE);
  assign slow   = decHot[REG_SFR] || decHot[REG_EXT];
  assign ack    = (heldHot[REG_SFR] && sfrAck) || (heldHot[REG_EXT] && extAck);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldHot   <= '0;
      heldWrite <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      rdValid <= (accept && !slow && !reqWrite) ||
                 ((state == ST_WAIT) && ack && !heldWrite);
      case (state)
        ST_IDLE: if (accept && slow) begin
          state     <= ST_WAIT;
          heldHot   <= decHot;
          heldWrite <= reqWrite;
        end
        ST_WAIT: if (ack) begin
          state   <= ST_IDLE;
          heldHot <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.latch   = accept && slow;
    ctl.iramWe  = accept && decHot[REG_IRAM] && reqWrite;
    ctl.eramWe  = accept && decHot[REG_ERAM] && reqWrite;
    ctl.iramRd  = accept && decHot[REG_IRAM] && !reqWrite;
    ctl.eramRd  = accept && decHot[REG_ERAM] && !reqWrite;
    ctl.takeSfr = (state == ST_WAIT) && heldHot[REG_SFR] && sfrAck && !heldWrite;
    ctl.takeExt = (state == ST_WAIT) && heldHot[REG_EXT] && extAck && !heldWrite;
  end

  assign busy      = (state == ST_WAIT);
  assign sfrReq    = busy && heldHot[REG_SFR];
  assign extReq    = busy && heldHot[REG_EXT];
  assign regionHot = busy ? heldHot : (reqValid ? decHot : '0);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionHot));

  assert_indirect_no_sfr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == MODE_INDIRECT) |=> !sfrReq);

  assert_ptr8_never_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == MODE_PTR8) |=> (!extReq && !busy));

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((sfrReq && !sfrAck) || (extReq && !extAck)) |=> busy);

  assert_fast_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && (reqMode == MODE_INDIRECT || reqMode == MODE_PTR8))
      |=> (rdValid && !busy));
endmodule

// File: rtl/dmr_datapath.sv
module dmr_datapath
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sfrRdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [DATA_W-1:0] heldWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH   = 2 ** LOCAL_W;
  localparam int N_BANKS = 2;
  localparam logic [1:0] SRC_IRAM = 2'd0, SRC_ERAM = 2'd1, SRC_SLOW = 2'd2;

  logic [LOCAL_W-1:0] idx;
  logic [N_BANKS-1:0] bankWe;
  logic [1:0]         rdSrc;
  logic [DATA_W-1:0]  slowQ;

  assign idx    = reqAddr[LOCAL_W-1:0];
  assign bankWe = {ctl.eramWe, ctl.iramWe};

  // bank 0 = internal RAM, bank 1 = expanded RAM
  for (genvar g = 0; g < N_BANKS; g++) begin : gBank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (bankWe[g]) mem[idx] <= reqWdata;
      q <= mem[idx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldWdata <= '0;
      rdSrc     <= SRC_IRAM;
      slowQ     <= '0;
    end else begin
      if (ctl.latch) begin
        heldAddr  <= reqAddr;
        heldWdata <= reqWdata;
      end
      if (ctl.iramRd) rdSrc <= SRC_IRAM;
      else if (ctl.eramRd) rdSrc <= SRC_ERAM;
      else if (ctl.takeSfr || ctl.takeExt) rdSrc <= SRC_SLOW;
      if (ctl.takeSfr) slowQ <= sfrRdata;
      else if (ctl.takeExt) slowQ <= extRdata;
    end
  end

  always_comb begin
    unique case (rdSrc)
      SRC_ERAM: rdData = gBank[1].q;
      SRC_SLOW: rdData = slowQ;
      default:  rdData = gBank[0].q;
    endcase
  end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 8,
  parameter int DATA_W  = 8,
  localparam int HI_W   = ADDR_W - LOCAL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqMode,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   busy,
  output logic [NUM_REGIONS-1:0] regionHot,
  output logic                   sfrReq,
  output logic                   sfrWrite,
  output logic [LOCAL_W-1:0]     sfrAddr,
  output logic [DATA_W-1:0]      sfrWdata,
  input  logic                   sfrAck,
  input  logic [DATA_W-1:0]      sfrRdata,
  output logic                   extReq,
  output logic                   extWrite,
  output logic [HI_W-1:0]        extAddrHi,
  output logic [LOCAL_W-1:0]     extAddrLo,
  output logic [DATA_W-1:0]      extWdata,
  output logic                   extRdN,
  output logic                   extWrN,
  input  logic                   extAck,
  input  logic [DATA_W-1:0]      extRdata
);
  dpCtl_t ctl;
  logic heldWrite;
  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldWdata;

  dmr_ctrl #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMode(reqMode), .reqAddr(reqAddr), .sfrAck(sfrAck), .extAck(extAck),
    .ctl(ctl), .busy(busy), .rdValid(rdValid), .heldWrite(heldWrite),
    .sfrReq(sfrReq), .extReq(extReq), .regionHot(regionHot)
  );

  dmr_datapath #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sfrRdata(sfrRdata), .extRdata(extRdata), .heldAddr(heldAddr),
    .heldWdata(heldWdata), .rdData(rdData)
  );

  assign sfrWrite  = sfrReq && heldWrite;
  assign sfrAddr   = sfrReq ? heldAddr[LOCAL_W-1:0] : '0;
  assign sfrWdata  = sfrWrite ? heldWdata : '0;
  assign extWrite  = extReq && heldWrite;
  assign extAddrHi = extReq ? heldAddr[ADDR_W-1:LOCAL_W] : '0;
  assign extAddrLo = extReq ? heldAddr[LOCAL_W-1:0] : '0;
  assign extWdata  = extWrite ? heldWdata : '0;
  assign extRdN    = !(extReq && !heldWrite);
  assign extWrN    = !extWrite;

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!extRdN || !extWrN) |-> (extReq && (extRdN || extWrN)));

  assert_eram_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    regionHot[REG_ERAM] |-> (extRdN && extWrN && extAddrLo == '0 && extWdata == '0));
endmodule

// File: tb/tb_dmem_router.sv
module tb_dmem_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, sfrAck = 0, extAck = 0;
  logic [1:0] reqMode = 0;
  logic [15:0] reqAddr = 0;
  logic [7:0] reqWdata = 0, sfrRdata = 0, extRdata = 0;
  logic [7:0] rdData, sfrAddr, sfrWdata, extAddrHi, extAddrLo, extWdata;
  logic rdValid, busy, sfrReq, sfrWrite, extReq, extWrite, extRdN, extWrN;
  logic [3:0] regionHot;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] iramM [256];
  logic [7:0] eramM [256];
  bit iramK [256];
  bit eramK [256];

  dmem_router dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expRegion(input logic [1:0] m, input logic [15:0] a);
    case (m)
      2'd0: return a[7] ? 4'b0010 : 4'b0001;
      2'd1: return 4'b0001;
      2'd2: return 4'b0100;
      default: return (a[15:8] == 0) ? 4'b0100 : 4'b1000;
    endcase
  endfunction

  // one complete access; called at a negedge, returns at a negedge
  task automatic access(input logic [1:0] m, input logic [15:0] a, input bit wr,
                        input logic [7:0] wd, input int dly, input bit poke,
                        output logic [7:0] rd);
    logic [3:0] er;
    logic [7:0] resp;
    er = expRegion(m, a);
    rd = 'x;
    reqValid = 1; reqWrite = wr; reqMode = m; reqAddr = a; reqWdata = wd;
    #1;
    chk(regionHot == er, "R8 regionHot in request cycle", regionHot, er);
    @(posedge clk); @(negedge clk);
    reqValid = 0; reqWrite = 0;
    if (er[0] || er[2]) begin
      chk(busy == 0, "R9 no stall for RAM access", busy, 0);
      chk(extRdN && extWrN && extAddrLo == 0 && !extReq, "R4 R6 no external activity",
          {extReq, extRdN, extWrN, extAddrLo}, {1'b0, 1'b1, 1'b1, 8'h0});
      if (wr) begin
        if (er[0]) begin iramM[a[7:0]] = wd; iramK[a[7:0]] = 1; end
        else begin eramM[a[7:0]] = wd; eramK[a[7:0]] = 1; end
      end else begin
        chk(rdValid == 1, "R9 rdValid one cycle after read", rdValid, 1);
        rd = rdData;
        if (er[0] && iramK[a[7:0]])
          chk(rdData == iramM[a[7:0]], "R1 R3 internal RAM data", rdData, iramM[a[7:0]]);
        if (er[2] && eramK[a[7:0]])
          chk(rdData == eramM[a[7:0]], "R4 R5 R7 expanded RAM data", rdData, eramM[a[7:0]]);
      end
    end else begin
      chk(busy == 1, "R10 busy after slow accept", busy, 1);
      chk(regionHot == er, "R8 regionHot held while busy", regionHot, er);
      if (er[1]) begin
        chk(sfrReq && !extReq && sfrAddr == a[7:0] && sfrWrite == wr,
            "R2 SFR request fields", {sfrReq, extReq, sfrWrite, sfrAddr},
            {1'b1, 1'b0, wr, a[7:0]});
        if (wr) chk(sfrWdata == wd, "R2 SFR write data", sfrWdata, wd);
      end else begin
        chk(extReq && !sfrReq && extAddrHi == a[15:8] && extAddrLo == a[7:0],
            "R5 R6 external address", {extReq, sfrReq, extAddrHi, extAddrLo},
            {1'b1, 1'b0, a});
        chk(extRdN == wr && extWrN == !wr, "R6 external strobes",
            {extRdN, extWrN}, {wr, !wr});
        if (wr) chk(extWdata == wd, "R6 external write data", extWdata, wd);
      end
      if (poke) begin
        reqValid = 1; reqWrite = 1; reqMode = 2'd1; reqAddr = 16'h0033; reqWdata = ~iramM[8'h33];
      end
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(busy == 1, "R10 busy until acknowledge", busy, 1);
      end
      resp = 8'($urandom);
      if (er[1]) begin sfrAck = 1; sfrRdata = resp; end
      else begin extAck = 1; extRdata = resp; end
      @(negedge clk);
      sfrAck = 0; extAck = 0; reqValid = 0; reqWrite = 0;
      chk(busy == 0 && !sfrReq && !extReq, "R10 released after acknowledge",
          {busy, sfrReq, extReq}, 0);
      chk(rdValid == !wr, "R10 rdValid after acknowledge", rdValid, !wr);
      if (!wr) begin
        rd = rdData;
        chk(rdData == resp, "R10 returned byte", rdData, resp);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin iramK[i] = 0; eramK[i] = 0; end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !rdValid && !sfrReq && !extReq && regionHot == 0 && extRdN && extWrN,
        "R12 reset outputs", {busy, rdValid, sfrReq, extReq, regionHot, extRdN, extWrN},
        7'b0000_0000_11);
    rstN = 1;
    @(negedge clk);

    // R1 direct low RAM shared with indirect
    access(2'd0, 16'h0010, 1, 8'hC3, 0, 0, rd);
    access(2'd1, 16'h0010, 0, 0, 0, 0, rd);
    chk(rd == 8'hC3, "R1 direct write read back indirectly", rd, 8'hC3);
    access(2'd0, 16'h007F, 1, 8'h7E, 0, 0, rd);
    access(2'd0, 16'h007F, 0, 0, 0, 0, rd);
    // R3 upper RAM vs SFR at A0h
    access(2'd1, 16'h00A0, 1, 8'h5A, 0, 0, rd);
    access(2'd0, 16'h00A0, 1, 8'hE1, 2, 0, rd);
    access(2'd0, 16'h0080, 0, 0, 0, 0, rd);
    access(2'd1, 16'h00A0, 0, 0, 0, 0, rd);
    chk(rd == 8'h5A, "R3 upper RAM untouched by SFR write", rd, 8'h5A);
    access(2'd1, 16'h00FF, 1, 8'h99, 0, 0, rd);
    // R4 pointer8 ignores high byte, reaches expanded RAM
    access(2'd2, 16'h37A0, 1, 8'h3C, 0, 0, rd);
    access(2'd3, 16'h00A0, 0, 0, 0, 0, rd);
    chk(rd == 8'h3C, "R4 R5 pointer8 write seen at 00A0 via pointer16", rd, 8'h3C);
    access(2'd1, 16'h00A0, 0, 0, 0, 0, rd);
    chk(rd == 8'h5A, "R7 internal RAM separate from expanded RAM", rd, 8'h5A);
    // R5 boundary
    access(2'd3, 16'h00FF, 1, 8'h11, 0, 0, rd);
    access(2'd2, 16'hFFFF, 0, 0, 0, 0, rd);
    chk(rd == 8'h11, "R5 00FF is expanded RAM", rd, 8'h11);
    access(2'd3, 16'h0100, 1, 8'h22, 1, 0, rd);
    access(2'd3, 16'hFFFF, 0, 0, 3, 0, rd);
    access(2'd3, 16'h0100, 0, 0, 0, 0, rd);
    // R11 idle cycle with write high changes nothing
    access(2'd1, 16'h0033, 1, 8'h44, 0, 0, rd);
    reqValid = 0; reqWrite = 1; reqMode = 2'd1; reqAddr = 16'h0033; reqWdata = 8'hBB;
    @(negedge clk);
    reqWrite = 0;
    #1;
    chk(regionHot == 0, "R8 regionHot zero without request", regionHot, 0);
    access(2'd1, 16'h0033, 0, 0, 0, 0, rd);
    chk(rd == 8'h44, "R11 idle write ignored", rd, 8'h44);
    // R11 request while busy ignored
    access(2'd3, 16'h4567, 0, 0, 2, 1, rd);
    access(2'd0, 16'h00C0, 1, 8'h01, 1, 1, rd);
    access(2'd1, 16'h0033, 0, 0, 0, 0, rd);
    chk(rd == 8'h44, "R11 write during busy ignored", rd, 8'h44);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      logic [15:0] a;
      m = 2'($urandom_range(0, 3));
      a = 16'($urandom);
      if (m == 2'd3 && $urandom_range(0, 1) == 0) a[15:8] = 0;
      access(m, a, 1'($urandom_range(0, 1)), 8'($urandom), int'($urandom_range(0, 3)),
             ($urandom_range(0, 7) == 0), rd);
    end
    access(2'd1, 16'h0033, 0, 0, 0, 0, rd);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule